// File: doc/BRIEF.md
# Gate driver fault supervisor

This block watches the health inputs of a half-bridge gate driver and decides when the high-side and low-side gates may be driven. It takes four conditions: gate-supply undervoltage, logic-reference undervoltage, bootstrap undervoltage, and a digital junction-temperature code. It also takes one run/sleep control line. From these it produces a fault flag, a sleep indication and one inhibit signal per gate for the downstream command logic. The analog comparators and regulators that produce the condition inputs are outside this block.

The faults behave differently from one another. Gate-supply undervoltage and overtemperature are sticky: each sets a latch that keeps the fault flag raised. Only the undervoltage holds the gates off, and only while the undervoltage is present. Overtemperature never holds the gates off. Reference undervoltage and bootstrap undervoltage are live conditions with no memory. Reference undervoltage blocks both gates; bootstrap undervoltage blocks only the high side.

The control line is first synchronised. A low period of moderate length on the line clears the latch. A long low period puts the block to sleep. After sleep, the block holds the gates off until both supplies are good.

Top module: `gate_fault_supervisor`

## Requirements
- R1: While `rst_n` is sampled low, and after it, until the control line has been high, the block reports `sleep_o`=1, `fault_flag`=1, `inhibit_hi`=1 and `inhibit_lo`=1.
- R2: `uv_gate`=1 sets both inhibits in the same cycle and raises `fault_flag`, and also sets the latch. Once `uv_gate` returns to 0, both inhibits fall in the same cycle, while `fault_flag` stays 1 until the latch is cleared.
- R3: `uv_ref`=1 sets both inhibits and `fault_flag` in the same cycle. When it returns to 0, all three fall again, because no latch is set by it.
- R4: `uv_boot`=1 sets `inhibit_hi` and `fault_flag` but leaves `inhibit_lo` at 0. It is not latched.
- R5: A `temp_code` greater than TEMP_TRIP (default 170) marks overtemperature. The mark is released only when the code is at or below TEMP_TRIP-TEMP_HYST (default 155). Overtemperature sets the latch and never drives either inhibit.
- R6: The latch is cleared when the synchronised control line stays low for at least CLR_MIN_CYC cycles. A shorter low period leaves it set.
- R7: While the synchronised line is low and the block is not asleep, `fault_flag` is 0 even with `uv_boot`=1.
- R8: When the line returns high, the latch sets again if `uv_gate` or overtemperature is still present.
- R9: The line passes through two synchronising flops. A low period longer than SLEEP_CYC cycles enters sleep: `sleep_o`=1, and `fault_flag` and both inhibits are 1 for as long as the line stays low.
- R10: After sleep, once the line is high, both inhibits and `fault_flag` stay 1 until `uv_gate` and `uv_ref` are both 0. A `uv_gate` seen during this wake phase does not set the latch.
- R11: Both inhibits are 1 whenever the synchronised line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| run_line | input | 1 | Asynchronous run/sleep control line, high = run |
| uv_gate | input | 1 | Gate-supply undervoltage condition |
| uv_ref | input | 1 | Logic-reference undervoltage condition |
| uv_boot | input | 1 | Bootstrap capacitor undervoltage condition |
| temp_code | input | TEMP_W | Junction temperature code |
| fault_flag | output | 1 | Fault indication, active high |
| sleep_o | output | 1 | Block is in sleep |
| inhibit_hi | output | 1 | High-side gate must be held off |
| inhibit_lo | output | 1 | Low-side gate must be held off |

## Verification
The latch and the thermal mark are internal. When either is in the wrong state, it shows as a `fault_flag` that is still high a few cycles after a qualifying clear pulse, or as a flag that is low right after the line returns high while a sticky cause persists. A wrong low-period count shows at the exact pulse widths around CLR_MIN_CYC and SLEEP_CYC, within two synchroniser cycles of the line edge. The bench therefore sweeps every width across both limits and every temperature code across both thresholds. A wrong power state shows immediately as inhibits that are released too early after a wake.

// File: rtl/gfs_pkg.sv
// Shared types for the gate driver fault supervisor.
package gfs_pkg;
    // Power state of the supervisor
    typedef enum logic [1:0] {
        PS_SLEEP = 2'd0,
        PS_WAKE  = 2'd1,
        PS_RUN   = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/gfs_sync.sv
// Multi-stage synchroniser for one asynchronous level.
// Assumes the input is a slow level; resets to 0 (line treated as low).
module gfs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Capture the asynchronous level
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= 1'b0;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Shift toward the synchronised output
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[i] <= 1'b0;
                    else        stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gfs_thermal.sv
// Overtemperature detector with hysteresis on a digital code.
// Assumes TEMP_HYST < TEMP_TRIP and both fit in TEMP_W bits.
module gfs_thermal #(
    parameter int TEMP_W    = 8,
    parameter int TEMP_TRIP = 170,
    parameter int TEMP_HYST = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              hot_q
);
    localparam logic [TEMP_W-1:0] TRIP_LVL = TEMP_W'(TEMP_TRIP);
    localparam logic [TEMP_W-1:0] REL_LVL  = TEMP_W'(TEMP_TRIP - TEMP_HYST);

    // Set above the trip level, release at or below the release level
    always_ff @(posedge clk) begin
        if (!rst_n)     hot_q <= 1'b0;
        else if (hot_q) hot_q <= (temp_code > REL_LVL);
        else            hot_q <= (temp_code > TRIP_LVL);
    end
endmodule

// File: rtl/gfs_line_timer.sv
// Measures low periods of the synchronised run line and sequences power.
// A low period of CLR_MIN_CYC cycles requests a latch clear; one longer than
// SLEEP_CYC enters sleep. After sleep the wake phase lasts until both supplies
// are good. Assumes 1 <= CLR_MIN_CYC <= SLEEP_CYC.
module gfs_line_timer
    import gfs_pkg::*;
#(
    parameter int CLR_MIN_CYC = 250,
    parameter int SLEEP_CYC   = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_s,
    input  logic uv_gate,
    input  logic uv_ref,
    output logic clr_req,
    output logic sleep_q,
    output logic wake_q
);
    localparam int CNT_W = $clog2(SLEEP_CYC + 1);
    localparam logic [CNT_W-1:0] CLR_LIM = CNT_W'(CLR_MIN_CYC - 1);
    localparam logic [CNT_W-1:0] SLP_LIM = CNT_W'(SLEEP_CYC);

    logic [CNT_W-1:0] low_cnt;
    pwr_state_t       state_q;

    // Count low cycles, saturating at the sleep limit
    always_ff @(posedge clk) begin
        if (!rst_n || run_s)       low_cnt <= '0;
        else if (low_cnt != SLP_LIM) low_cnt <= low_cnt + 1'b1;
    end

    assign clr_req = !run_s && (low_cnt >= CLR_LIM);

    // Power state sequencing: sleep, wake, run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_SLEEP;
        end else begin
            case (state_q)
                PS_SLEEP: if (run_s) state_q <= PS_WAKE;
                PS_WAKE: begin
                    if (!run_s && low_cnt >= SLP_LIM)  state_q <= PS_SLEEP;
                    else if (run_s && !uv_gate && !uv_ref) state_q <= PS_RUN;
                end
                PS_RUN:  if (!run_s && low_cnt >= SLP_LIM) state_q <= PS_SLEEP;
                default: state_q <= PS_SLEEP;
            endcase
        end
    end

    assign sleep_q = (state_q == PS_SLEEP);
    assign wake_q  = (state_q == PS_WAKE);
endmodule

// File: rtl/gfs_checker.sv
// Property checker for the gate driver fault supervisor, bound to the top.
module gfs_checker (
    input logic clk,
    input logic rst_n,
    input logic run_s,
    input logic clr_req,
    input logic sleep_q,
    input logic wake_q,
    input logic latch_q,
    input logic hot_q,
    input logic uv_gate,
    input logic uv_ref,
    input logic fault_flag,
    input logic inhibit_hi,
    input logic inhibit_lo
);
    AST_UVGATE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (run_s && !sleep_q && !wake_q && uv_gate) |=> (latch_q && (fault_flag || !run_s))); // R2
    AST_UVREF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        uv_ref |-> (inhibit_lo && inhibit_hi && (fault_flag || !run_s))); // R3
    AST_HOT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_q && run_s && !sleep_q && !wake_q) |=> latch_q); // R5
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !latch_q); // R6
    AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_s && !sleep_q) |-> !fault_flag); // R7
    AST_SLEEP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_q |-> (fault_flag && inhibit_lo && inhibit_hi)); // R9
    AST_SLEEP_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_q) |-> !$past(run_s)); // R9
    AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> (inhibit_lo && inhibit_hi)); // R10
    AST_LOW_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
        !run_s |-> (inhibit_lo && inhibit_hi)); // R11
endmodule

bind gate_fault_supervisor gfs_checker i_gfs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_s      (run_s),
    .clr_req    (clr_req),
    .sleep_q    (sleep_q),
    .wake_q     (wake_q),
    .latch_q    (latch_q),
    .hot_q      (hot_q),
    .uv_gate    (uv_gate),
    .uv_ref     (uv_ref),
    .fault_flag (fault_flag),
    .inhibit_hi (inhibit_hi),
    .inhibit_lo (inhibit_lo)
);

// File: rtl/gate_fault_supervisor.sv
// Gate driver fault supervisor: merges sticky and live fault conditions with
// a run/sleep line into a fault flag, sleep indication and per-gate inhibits.
// Assumes condition inputs are already synchronous to clk; run_line may be
// asynchronous. Inhibits follow the live undervoltage inputs combinationally.
module gate_fault_supervisor #(
    parameter int TEMP_W      = 8,
    parameter int TEMP_TRIP   = 170,
    parameter int TEMP_HYST   = 15,
    parameter int CLR_MIN_CYC = 250,
    parameter int SLEEP_CYC   = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_line,
    input  logic              uv_gate,
    input  logic              uv_ref,
    input  logic              uv_boot,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              fault_flag,
    output logic              sleep_o,
    output logic              inhibit_hi,
    output logic              inhibit_lo
);
    logic run_s;
    logic clr_req;
    logic sleep_q;
    logic wake_q;
    logic hot_q;
    logic latch_q;
    logic in_run;

    gfs_sync #(.STAGES(2)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (run_line),
        .q_sync  (run_s)
    );

    gfs_thermal #(
        .TEMP_W    (TEMP_W),
        .TEMP_TRIP (TEMP_TRIP),
        .TEMP_HYST (TEMP_HYST)
    ) i_thermal (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_code (temp_code),
        .hot_q     (hot_q)
    );

    gfs_line_timer #(
        .CLR_MIN_CYC (CLR_MIN_CYC),
        .SLEEP_CYC   (SLEEP_CYC)
    ) i_line_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_s   (run_s),
        .uv_gate (uv_gate),
        .uv_ref  (uv_ref),
        .clr_req (clr_req),
        .sleep_q (sleep_q),
        .wake_q  (wake_q)
    );

    assign in_run = run_s && !sleep_q && !wake_q;

    // Sticky fault latch: cleared by a qualifying low pulse, set in run
    always_ff @(posedge clk) begin
        if (!rst_n || clr_req)              latch_q <= 1'b0;
        else if (in_run && (uv_gate || hot_q)) latch_q <= 1'b1;
    end

    // Output decode: flag masked during a clear pulse, forced in sleep
    always_comb begin
        inhibit_lo = !run_s || sleep_q || wake_q || uv_gate || uv_ref;
        inhibit_hi = inhibit_lo || uv_boot;
        fault_flag = sleep_q ||
                     (run_s && (latch_q || wake_q || hot_q ||
                                uv_gate || uv_ref || uv_boot));
        sleep_o    = sleep_q;
    end
endmodule

// File: tb/test_gate_fault_supervisor.sv
module test_gate_fault_supervisor;
    localparam int CLRN  = 4;
    localparam int SLPN  = 12;
    localparam int TRIP  = 170;
    localparam int HYST  = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_line = 1'b0;
    logic uv_gate = 1'b0, uv_ref = 1'b0, uv_boot = 1'b0;
    logic [7:0] temp_code = 8'd25;
    logic fault_flag, sleep_o, inhibit_hi, inhibit_lo;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gate_fault_supervisor #(
        .TEMP_W(8), .TEMP_TRIP(TRIP), .TEMP_HYST(HYST),
        .CLR_MIN_CYC(CLRN), .SLEEP_CYC(SLPN)
    ) i_gate_fault_supervisor (
        .clk(clk), .rst_n(rst_n), .run_line(run_line),
        .uv_gate(uv_gate), .uv_ref(uv_ref), .uv_boot(uv_boot),
        .temp_code(temp_code), .fault_flag(fault_flag), .sleep_o(sleep_o),
        .inhibit_hi(inhibit_hi), .inhibit_lo(inhibit_lo)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Low pulse of w cycles on the line, then settle
    task automatic pulse_low(input int w);
        run_line = 1'b0;
        tick(w);
        run_line = 1'b1;
        tick(6);
    endtask

    initial begin
        tick(3);
        check("R1 sleep", sleep_o, 1);
        check("R1 flag", fault_flag, 1);
        check("R1 inh", {inhibit_hi, inhibit_lo}, 3);
        rst_n = 1'b1;
        tick(2);
        check("R1 after reset", {sleep_o, fault_flag, inhibit_hi, inhibit_lo}, 15);
        run_line = 1'b1;
        tick(8);
        check("R10 wake clean", {sleep_o, fault_flag, inhibit_hi, inhibit_lo}, 0);

        // R2 gate-supply undervoltage
        uv_gate = 1'b1; #1;
        check("R2 inh on", {inhibit_hi, inhibit_lo}, 3);
        check("R2 flag on", fault_flag, 1);
        tick(3);
        uv_gate = 1'b0; #1;
        check("R2 inh off", {inhibit_hi, inhibit_lo}, 0);
        check("R2 flag latched", fault_flag, 1);
        tick(3);
        pulse_low(CLRN);
        check("R6 cleared", fault_flag, 0);

        // R3 reference undervoltage
        uv_ref = 1'b1; #1;
        check("R3 on", {fault_flag, inhibit_hi, inhibit_lo}, 7);
        tick(4);
        uv_ref = 1'b0; #1;
        check("R3 off", {fault_flag, inhibit_hi, inhibit_lo}, 0);

        // R4 bootstrap undervoltage
        uv_boot = 1'b1; #1;
        check("R4 on", {fault_flag, inhibit_hi, inhibit_lo}, 6);
        tick(4);
        // R7 flag quiet in a clear pulse; R11 inhibits during low
        run_line = 1'b0;
        tick(4);
        check("R7 quiet", fault_flag, 0);
        check("R11 low inh", {inhibit_hi, inhibit_lo}, 3);
        run_line = 1'b1;
        tick(4);
        check("R7 back", fault_flag, 1);
        uv_boot = 1'b0; #1;
        check("R4 not latched", {fault_flag, inhibit_hi, inhibit_lo}, 0);
        tick(2);

        // R6/R9 width sweep across both limits
        for (int w = 1; w <= SLPN + 3; w++) begin
            bit seen = 1'b0;
            uv_gate = 1'b1; tick(2); uv_gate = 1'b0; tick(1);
            run_line = 1'b0;
            for (int k = 0; k < w; k++) begin tick(1); seen |= sleep_o; end
            run_line = 1'b1;
            for (int k = 0; k < 3; k++) begin tick(1); seen |= sleep_o; end
            tick(6);
            check($sformatf("R9 sleep w=%0d", w), seen, (w > SLPN) ? 1 : 0);
            check($sformatf("R6 clear w=%0d", w), fault_flag, (w < CLRN) ? 1 : 0);
        end
        pulse_low(CLRN);

        // R8 cause persists across the clear pulse
        uv_gate = 1'b1; tick(2);
        pulse_low(CLRN);
        check("R8 relatch flag", fault_flag, 1);
        uv_gate = 1'b0; #1;
        check("R8 still latched", fault_flag, 1);
        tick(2);
        pulse_low(CLRN);
        check("R8 cleared", fault_flag, 0);

        // R5 rising threshold sweep
        for (int t = 150; t <= 190; t++) begin
            temp_code = 8'(t); tick(3);
            check($sformatf("R5 no inhibit t=%0d", t), {inhibit_hi, inhibit_lo}, 0);
            check($sformatf("R5 trip t=%0d", t), fault_flag, (t > TRIP) ? 1 : 0);
            temp_code = 8'd25; tick(2);
            pulse_low(CLRN);
        end
        // R5 release threshold sweep, from hot
        for (int t = 140; t <= 175; t++) begin
            temp_code = 8'd200; tick(3);
            temp_code = 8'(t); tick(3);
            pulse_low(CLRN);
            check($sformatf("R5 release t=%0d", t), fault_flag, (t > TRIP - HYST) ? 1 : 0);
            temp_code = 8'd25; tick(3);
            pulse_low(CLRN);
        end

        // R9 sleep holds flag; R10 wake waits for both supplies
        run_line = 1'b0;
        tick(SLPN + 6);
        check("R9 in sleep", {sleep_o, fault_flag, inhibit_hi, inhibit_lo}, 15);
        uv_ref = 1'b1;
        run_line = 1'b1;
        tick(8);
        check("R10 ref wait", {sleep_o, fault_flag, inhibit_hi, inhibit_lo}, 7);
        uv_ref = 1'b0; uv_gate = 1'b1;
        tick(4);
        check("R10 gate wait", {sleep_o, fault_flag, inhibit_hi, inhibit_lo}, 7);
        uv_gate = 1'b0;
        tick(3);
        check("R10 no latch", {sleep_o, fault_flag, inhibit_hi, inhibit_lo}, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule